// File: doc/BRIEF.md
# Page-Mode DRAM Read Controller

This block sits between a host that wants single words and an asynchronous DRAM with separate row and column strobes. It takes read requests carrying a row and a column over a valid/ready handshake. It opens the row by placing the row address on a shared address bus and then dropping the row strobe. It then fetches the word by placing the column and pulsing the column strobe. The row stays open after the word is returned. A later request to that row costs only a column-strobe cycle. A request to another row first closes the page, waits out the precharge time, and then opens the new row.

The parameter `EDO_MODE` chooses when the returned word is latched. The choice depends on how the attached device drives its outputs. With `EDO_MODE = 0`, the device stops driving as soon as the column strobe goes high, so the word is latched on the edge that raises the strobe. With `EDO_MODE = 1`, the device keeps the last word on its pins until the column strobe falls again. The word is then latched one cycle after the strobe rises. The next column of the same row may be accepted in the last strobe-low cycle, so consecutive column cycles are one clock shorter. The strobe-low width, the row-to-column delay and the precharge time are parameters, counted in clock cycles.

Top module: `dram_page_reader`

## Requirements

In this list:
- A request is accepted on a rising edge where `reqValid` and `reqReady` are both high.
- Latency L means that `rdataValid` rises on the Lth rising edge after the accepting edge.
- RC, CL and PR stand for the parameters `RAS_CAS_CYC`, `CAS_LOW_CYC` and `PRECHG_CYC`.
- Both strobes are active low.

Requirements:
- R1: While reset is held and just after it, `dramRasN` and `dramCasN` are 1, `rdataValid` is 0 and `reqReady` is 1.
- R2: To open a row, the row address is driven for at least one cycle with `dramRasN` high and is held for one cycle after `dramRasN` falls. The column is then driven, and `dramCasN` falls exactly RC cycles after `dramRasN` fell. The word returned is the one stored at the requested row and column.
- R3: `dramCasN` stays low for exactly CL cycles per access, and `dramAddr` does not change while it is low.
- R4: `dramCasN` is low only while `dramRasN` is low. `dramRasN` changes only when `dramCasN` was high and stays high.
- R5: A request to the open row causes no row-strobe activity. With `EDO_MODE = 0` its latency is CL+1.
- R6: A request to a different row raises `dramRasN` on the accepting edge and keeps it high for exactly PR cycles before the new row opens. With `EDO_MODE = 0` the latency is PR+RC+CL. From reset, the latency of the first request is RC+CL+1.
- R7: With `EDO_MODE = 0`, the word is latched on the edge where `dramCasN` rises. For back-to-back requests to the open row, `rdataValid` pulses are CL+2 cycles apart, with `dramCasN` high for 2 cycles between accesses.
- R8: With `EDO_MODE = 1`, the word is latched one cycle after `dramCasN` rises, so each latency above grows by 1. A request to the open row can be accepted in the last strobe-low cycle. Back-to-back pulses are then CL+1 cycles apart, with `dramCasN` high for 1 cycle.
- R9: Each accepted request gives exactly one single-cycle `rdataValid` pulse, and the words return in request order.
- R10: `reqReady` is low in the cycle after any acceptance.
- R11: While `reqValid` is low, an open row stays open and `dramRasN` does not move, whatever `reqRow` holds.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqRow | input | ADDR_W | Row of the request |
| reqCol | input | ADDR_W | Column of the request |
| rdataValid | output | 1 | One-cycle pulse: `rdata` holds a returned word |
| rdata | output | DATA_W | Returned word |
| dramRasN | output | 1 | Row strobe to the DRAM, active low |
| dramCasN | output | 1 | Column strobe to the DRAM, active low |
| dramAddr | output | ADDR_W | Multiplexed row/column address |
| dramDq | input | DATA_W | Data from the DRAM |

## Verification

The assertions assume that the host follows the handshake: a request is taken only on an edge where ready is high, and its row and column are stable during that cycle. The pulse-spacing check also assumes that the column-strobe width is at least one cycle, so two returned words can never fall in adjacent cycles. The bench changes request fields only on falling edges and keeps `reqValid` high until it sees ready. A small device model in the bench drives a poison word whenever its outputs would not be valid. Latching at the wrong moment for the chosen output mode therefore shows up as wrong data.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RCD,
    ST_COLSET,
    ST_CASLO,
    ST_OPEN
  } ctlState_t;

  typedef struct packed {
    logic loadReq;
    logic driveRow;
    logic driveColReq;
    logic driveColReg;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/dpr_datapath.sv
`timescale 1ns/1ps
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [DATA_W-1:0] dramDq,
  output logic              rowHit,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rdataValid
);

  logic [ADDR_W-1:0] openRowQ;
  logic [ADDR_W-1:0] colQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              validQ;

  // The row register holds the row that is open whenever the controller is in a page.
  assign rowHit = (reqRow == openRowQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openRowQ <= '0;
      colQ     <= '0;
    end else if (stb.loadReq) begin
      openRowQ <= reqRow;
      colQ     <= reqCol;
    end
  end

  // The address bus is registered, so it never glitches between row and column.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (stb.driveRow) begin
      addrQ <= reqRow;
    end else if (stb.driveColReq) begin
      addrQ <= reqCol;
    end else if (stb.driveColReg) begin
      addrQ <= colQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= stb.capture;
      if (stb.capture) begin
        dataQ <= dramDq;
      end
    end
  end

  assign dramAddr   = addrQ;
  assign rdata      = dataQ;
  assign rdataValid = validQ;

endmodule

// File: rtl/dpr_ctrl.sv
`timescale 1ns/1ps
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter bit EDO_MODE    = 1'b0,
  parameter int RAS_CAS_CYC = 2,
  parameter int CAS_LOW_CYC = 1,
  parameter int PRECHG_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowHit,
  output logic       reqReady,
  output logic       dramRasN,
  output logic       dramCasN,
  output dpStrobe_t  stb
);

  localparam int MAX_CYC = (RAS_CAS_CYC > CAS_LOW_CYC) ?
                           ((RAS_CAS_CYC > PRECHG_CYC) ? RAS_CAS_CYC : PRECHG_CYC) :
                           ((CAS_LOW_CYC > PRECHG_CYC) ? CAS_LOW_CYC : PRECHG_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_t  stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic rasQ, rasD;
  logic casQ, casD;
  logic capQ, capD;
  logic ready;
  logic accept;

  always_comb begin
    unique case (stateQ)
      ST_IDLE, ST_OPEN: ready = 1'b1;
      ST_CASLO:         ready = EDO_MODE && (cntQ == '0) && rowHit;
      default:          ready = 1'b0;
    endcase
  end

  assign accept = reqValid && ready;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    rasD   = rasQ;
    casD   = casQ;
    capD   = 1'b0;
    stb    = '0;
    // In output-hold mode the latch happens one edge after the column strobe rises.
    if (EDO_MODE) begin
      stb.capture = capQ;
    end
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          stb.loadReq  = 1'b1;
          stb.driveRow = 1'b1;
          stateD       = ST_PRE;
          cntD         = '0;
        end
      end
      ST_PRE: begin
        if (cntQ == '0) begin
          rasD   = 1'b0;
          stateD = ST_RCD;
          cntD   = CNT_W'(RAS_CAS_CYC - 2);
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_RCD: begin
        if (cntQ == '0) begin
          stb.driveColReg = 1'b1;
          stateD          = ST_COLSET;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_COLSET: begin
        casD   = 1'b0;
        stateD = ST_CASLO;
        cntD   = CNT_W'(CAS_LOW_CYC - 1);
      end
      ST_CASLO: begin
        if (cntQ != '0) begin
          cntD = cntQ - 1'b1;
        end else begin
          casD = 1'b1;
          if (EDO_MODE) begin
            capD = 1'b1;
            if (accept) begin
              stb.loadReq     = 1'b1;
              stb.driveColReq = 1'b1;
              stateD          = ST_COLSET;
            end else begin
              stateD = ST_OPEN;
            end
          end else begin
            stb.capture = 1'b1;
            stateD      = ST_OPEN;
          end
        end
      end
      ST_OPEN: begin
        if (accept) begin
          stb.loadReq = 1'b1;
          if (rowHit) begin
            stb.driveColReq = 1'b1;
            stateD          = ST_COLSET;
          end else begin
            rasD         = 1'b1;
            stb.driveRow = 1'b1;
            stateD       = ST_PRE;
            cntD         = CNT_W'(PRECHG_CYC - 1);
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      rasQ   <= 1'b1;
      casQ   <= 1'b1;
      capQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      rasQ   <= rasD;
      casQ   <= casD;
      capQ   <= capD;
    end
  end

  assign reqReady = ready;
  assign dramRasN = rasQ;
  assign dramCasN = casQ;

endmodule

// File: rtl/dram_page_reader.sv
`timescale 1ns/1ps
module dram_page_reader
  import dpr_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter bit EDO_MODE    = 1'b0,
  parameter int RAS_CAS_CYC = 2,
  parameter int CAS_LOW_CYC = 1,
  parameter int PRECHG_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  output logic              rdataValid,
  output logic [DATA_W-1:0] rdata,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic [ADDR_W-1:0] dramAddr,
  input  logic [DATA_W-1:0] dramDq
);

  dpStrobe_t stb;
  logic      rowHit;

  dpr_ctrl #(
    .EDO_MODE   (EDO_MODE),
    .RAS_CAS_CYC(RAS_CAS_CYC),
    .CAS_LOW_CYC(CAS_LOW_CYC),
    .PRECHG_CYC (PRECHG_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .rowHit  (rowHit),
    .reqReady(reqReady),
    .dramRasN(dramRasN),
    .dramCasN(dramCasN),
    .stb     (stb)
  );

  dpr_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqRow    (reqRow),
    .reqCol    (reqCol),
    .dramDq    (dramDq),
    .rowHit    (rowHit),
    .dramAddr  (dramAddr),
    .rdata     (rdata),
    .rdataValid(rdataValid)
  );

endmodule

// File: rtl/dram_page_reader_chk.sv
`timescale 1ns/1ps
module dram_page_reader_chk #(
  parameter int ADDR_W      = 10,
  parameter int CAS_LOW_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rdataValid,
  input logic              dramRasN,
  input logic              dramCasN,
  input logic [ADDR_W-1:0] dramAddr
);

  logic [7:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (dramCasN) begin
      lowCnt <= '0;
    end else if (lowCnt != 8'hFF) begin
      lowCnt <= lowCnt + 8'd1;
    end
  end

  // R4
  a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);

  // R4
  a_r4_ras_moves_cas_high: assert property (@(posedge clk) disable iff (!rstN)
    (dramRasN != $past(dramRasN)) |-> (dramCasN && $past(dramCasN)));

  // R3
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasN && !$past(dramCasN)) |-> $stable(dramAddr));

  // R3
  a_r3_cas_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramCasN) |-> (lowCnt == 8'(CAS_LOW_CYC)));

  // R9
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdataValid |=> !rdataValid);

  // R10
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind dram_page_reader dram_page_reader_chk #(
  .ADDR_W     (ADDR_W),
  .CAS_LOW_CYC(CAS_LOW_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rdataValid(rdataValid),
  .dramRasN  (dramRasN),
  .dramCasN  (dramCasN),
  .dramAddr  (dramAddr)
);

// File: tb/dram_page_reader_bench.sv
`timescale 1ns/1ps
module dram_page_model #(
  parameter bit EDO_MODE    = 1'b0,
  parameter int CAS_LOW_CYC = 1
) (
  input  logic        clk,
  input  logic        rasN,
  input  logic        casN,
  input  logic [9:0]  addr,
  output logic [15:0] dq,
  output int          lastRasHigh,
  output int          lastCasHigh,
  output int          lastCasLow
);
  localparam logic [15:0] POISON = 16'hDEAD;

  function automatic logic [15:0] pat(input logic [9:0] r, input logic [9:0] c);
    return {r[7:0] ^ 8'hA5, c[7:0]};
  endfunction

  logic [9:0]  rowL = '0;
  logic        prevRas = 1'b1;
  logic        prevCas = 1'b1;
  int          casLowN = 0;
  int          rasHi = 0;
  int          casHi = 0;
  logic [15:0] held = POISON;
  logic        outOk;

  assign outOk = !casN && (casLowN >= CAS_LOW_CYC - 1);

  always_comb begin
    if (outOk) dq = pat(rowL, addr);
    else if (EDO_MODE && casN) dq = held;
    else dq = POISON;
  end

  initial begin
    lastRasHigh = 0;
    lastCasHigh = 0;
    lastCasLow  = 0;
  end

  always @(posedge clk) begin
    if (!rasN && prevRas) rowL <= addr;
    if (outOk) held <= pat(rowL, addr);
    if (rasN) rasHi <= rasHi + 1;
    else begin
      if (prevRas) lastRasHigh <= rasHi;
      rasHi <= 0;
    end
    if (!casN) begin
      casLowN <= casLowN + 1;
      if (prevCas) lastCasHigh <= casHi;
      casHi <= 0;
    end else begin
      if (!prevCas) lastCasLow <= casLowN;
      casLowN <= 0;
      casHi   <= (!rasN && prevRas) ? 1 : casHi + 1;
    end
    prevRas <= rasN;
    prevCas <= casN;
  end
endmodule

module dram_page_reader_bench;
  localparam int RC = 2;
  localparam int CL = 1;
  localparam int PR = 2;
  localparam int K_COLD = 0;
  localparam int K_HIT  = 1;
  localparam int K_MISS = 2;
  localparam int NVEC = 8;
  // {row, col, kind}
  localparam logic [21:0] VEC [NVEC] = '{
    {10'h012, 10'h003, 2'd0},
    {10'h012, 10'h004, 2'd1},
    {10'h012, 10'h3FF, 2'd1},
    {10'h155, 10'h000, 2'd2},
    {10'h155, 10'h2AA, 2'd1},
    {10'h3FF, 10'h001, 2'd2},
    {10'h000, 10'h3FF, 2'd2},
    {10'h000, 10'h080, 2'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid [2];
  logic [9:0]  reqRow [2];
  logic [9:0]  reqCol [2];
  logic        reqReady [2];
  logic        rdataValid [2];
  logic [15:0] rdata [2];
  logic        rasN [2];
  logic        casN [2];
  logic [9:0]  addr [2];
  logic [15:0] dq [2];
  int          lastRasHigh [2];
  int          lastCasHigh [2];
  int          lastCasLow [2];

  dram_page_reader #(.ADDR_W(10), .DATA_W(16), .EDO_MODE(1'b0),
    .RAS_CAS_CYC(RC), .CAS_LOW_CYC(CL), .PRECHG_CYC(PR)) u_dram_page_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqReady(reqReady[0]),
    .reqRow(reqRow[0]), .reqCol(reqCol[0]), .rdataValid(rdataValid[0]),
    .rdata(rdata[0]), .dramRasN(rasN[0]), .dramCasN(casN[0]),
    .dramAddr(addr[0]), .dramDq(dq[0]));

  dram_page_reader #(.ADDR_W(10), .DATA_W(16), .EDO_MODE(1'b1),
    .RAS_CAS_CYC(RC), .CAS_LOW_CYC(CL), .PRECHG_CYC(PR)) u_dram_page_reader_edo (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqReady(reqReady[1]),
    .reqRow(reqRow[1]), .reqCol(reqCol[1]), .rdataValid(rdataValid[1]),
    .rdata(rdata[1]), .dramRasN(rasN[1]), .dramCasN(casN[1]),
    .dramAddr(addr[1]), .dramDq(dq[1]));

  dram_page_model #(.EDO_MODE(1'b0), .CAS_LOW_CYC(CL)) u_model_fpm (
    .clk(clk), .rasN(rasN[0]), .casN(casN[0]), .addr(addr[0]), .dq(dq[0]),
    .lastRasHigh(lastRasHigh[0]), .lastCasHigh(lastCasHigh[0]), .lastCasLow(lastCasLow[0]));

  dram_page_model #(.EDO_MODE(1'b1), .CAS_LOW_CYC(CL)) u_model_edo (
    .clk(clk), .rasN(rasN[1]), .casN(casN[1]), .addr(addr[1]), .dq(dq[1]),
    .lastRasHigh(lastRasHigh[1]), .lastCasHigh(lastCasHigh[1]), .lastCasLow(lastCasLow[1]));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int cyc = 0;
  int vldCnt [2] = '{0, 0};
  int vCyc [2][64];
  logic [15:0] vData [2][64];

  function automatic logic [15:0] pat(input logic [9:0] r, input logic [9:0] c);
    return {r[7:0] ^ 8'hA5, c[7:0]};
  endfunction

  function automatic int expLat(input int m, input int kind);
    int l;
    if (kind == K_COLD) l = RC + CL + 1;
    else if (kind == K_HIT) l = CL + 1;
    else l = PR + RC + CL;
    return l + m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int m = 0; m < 2; m++) begin
      if (rdataValid[m] && vldCnt[m] < 64) begin
        vCyc[m][vldCnt[m]]  = cyc;
        vData[m][vldCnt[m]] = rdata[m];
        vldCnt[m]           = vldCnt[m] + 1;
      end
    end
  end

  task automatic waitNeg();
    @(negedge clk);
    #1;
  endtask

  // Presents a request and returns the cycle stamp taken just before the accepting edge.
  task automatic present(input int m, input logic [9:0] row, input logic [9:0] col,
                         output int accCyc);
    @(negedge clk);
    reqValid[m] = 1'b1;
    reqRow[m]   = row;
    reqCol[m]   = col;
    #1;
    for (int t = 0; t < 100; t++) begin
      if (reqReady[m]) break;
      waitNeg();
    end
    accCyc = cyc;
  endtask

  task automatic doRead(input int m, input logic [9:0] row, input logic [9:0] col,
                        input int kind);
    int base, accCyc, lat;
    base = vldCnt[m];
    present(m, row, col, accCyc);
    waitNeg();
    reqValid[m] = 1'b0;
    chk(reqReady[m] == 1'b0, "R10 ready low after accept", reqReady[m], 0);
    for (int t = 0; t < 100; t++) begin
      if (vldCnt[m] > base) break;
      waitNeg();
    end
    lat = vCyc[m][base] - accCyc - 1;
    chk(vData[m][base] == pat(row, col), "R2/R9 returned word", vData[m][base], pat(row, col));
    if (m == 0) begin
      if (kind == K_HIT) chk(lat == expLat(m, kind), "R5 hit latency", lat, expLat(m, kind));
      else chk(lat == expLat(m, kind), "R6 open latency", lat, expLat(m, kind));
      chk(vData[m][base] == pat(row, col), "R7 latch at strobe rise", vData[m][base], pat(row, col));
    end else begin
      chk(lat == expLat(m, kind), "R8 output-hold latency", lat, expLat(m, kind));
    end
    if (kind == K_MISS)
      chk(lastRasHigh[m] == PR, "R6 precharge width", lastRasHigh[m], PR);
    if (kind != K_HIT)
      chk(lastCasHigh[m] == RC, "R2 row-to-column delay", lastCasHigh[m], RC);
    chk(lastCasLow[m] == CL, "R3 strobe-low width", lastCasLow[m], CL);
    repeat (3) waitNeg();
    chk(vldCnt[m] == base + 1, "R9 one pulse per request", vldCnt[m], base + 1);
  endtask

  task automatic stream(input int m, input logic [9:0] row);
    int base, accCyc, gap;
    base = vldCnt[m];
    for (int i = 0; i < 4; i++) begin
      present(m, row, 10'(i + 1), accCyc);
    end
    @(negedge clk);
    reqValid[m] = 1'b0;
    for (int t = 0; t < 100; t++) begin
      if (vldCnt[m] >= base + 4) break;
      waitNeg();
    end
    for (int i = 0; i < 4; i++)
      chk(vData[m][base + i] == pat(row, 10'(i + 1)), "R9 stream order",
          vData[m][base + i], pat(row, 10'(i + 1)));
    for (int i = 0; i < 3; i++) begin
      gap = vCyc[m][base + i + 1] - vCyc[m][base + i];
      if (m == 0) chk(gap == CL + 2, "R7 page cycle spacing", gap, CL + 2);
      else chk(gap == CL + 1, "R8 overlapped spacing", gap, CL + 1);
    end
    if (m == 0) chk(lastCasHigh[m] == 2, "R7 strobe-high gap", lastCasHigh[m], 2);
    else chk(lastCasHigh[m] == 1, "R8 strobe-high gap", lastCasHigh[m], 1);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      reqValid[m] = 1'b0;
      reqRow[m]   = '0;
      reqCol[m]   = '0;
    end
    repeat (4) waitNeg();
    for (int m = 0; m < 2; m++) begin
      chk(rasN[m] && casN[m], "R1 strobes high in reset", {rasN[m], casN[m]}, 3);
      chk(!rdataValid[m], "R1 no data in reset", rdataValid[m], 0);
    end
    rstN = 1'b1;
    waitNeg();
    for (int m = 0; m < 2; m++)
      chk(reqReady[m] && rasN[m], "R1 ready after reset", reqReady[m], 1);

    for (int i = 0; i < NVEC; i++)
      for (int m = 0; m < 2; m++)
        doRead(m, VEC[i][21:12], VEC[i][11:2], int'(VEC[i][1:0]));

    // Row 0 is open now: stream column hits back to back.
    for (int m = 0; m < 2; m++) stream(m, 10'h000);

    // R11: a different row offered without valid must not close the page.
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      reqRow[m] = 10'h2C3;
      reqCol[m] = 10'h011;
      repeat (6) begin
        waitNeg();
        chk(!rasN[m] && casN[m] && !rdataValid[m], "R11 page untouched without valid",
            {rasN[m], rdataValid[m]}, 0);
      end
      doRead(m, 10'h000, 10'h055, K_HIT);
      chk(vData[m][vldCnt[m] - 1] == pat(10'h000, 10'h055), "R11 row still open",
          vData[m][vldCnt[m] - 1], pat(10'h000, 10'h055));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule